// File: doc/BRIEF.md
# Byte Serial Peripheral Port (Master or Slave)

This block is a byte-wide SPI port with a small register file for a host processor. As bus master it generates the serial clock from the system clock and starts a full-duplex transfer whenever the host writes the data register. As slave it follows a clock supplied by an external master. In slave mode it can optionally respond only while the active-low select input is asserted.

The port supports three per-port settings, all configurable by software:
- whether the most or the least significant bit goes out first;
- the idle level of the serial clock;
- which of the two clock edges samples incoming data.

Completion of every 8-bit transfer sets a sticky flag that also drives an interrupt line. A host write to the data register while a byte is in flight is dropped, and it sets a sticky collision flag. Software clears each flag by writing 0 to it.

The register map uses the address `wr_addr`/`rd_addr`:
- Address 0 is control. Bit 0 is enable, bit 1 is master (1) or slave (0), bit 2 is MSB-first (1) or LSB-first (0), bit 3 is select-pin enable, bit 4 is clock idle high, bit 5 is trailing-edge sampling, and bits 7:6 are the divider code.
- Address 1 is status. Bit 0 is done and bit 1 is collision.
- Address 2 is data: writes load the shift register and reads return it.

Reads are registered, with one cycle of latency.

Top module: `spi_port`

## Requirements
- R1: With control bit 0 at 0, `sck_oe`, `sdo_oe` and `ss_n_oe` stay 0, no serial clock toggles, and a data write only loads the register without starting a transfer or setting done.
- R2: In master mode (bits 0 and 1 set), a data write while idle starts a full-duplex 8-bit transfer. Afterwards the data register holds the byte received on `sdi_i`, and the byte written has appeared on `sdo_o`.
- R3: Control bit 2 = 1 sends and receives the most significant bit first; bit 2 = 0 sends and receives the least significant bit first.
- R4: Control bit 4 sets the idle level of the serial clock. Control bit 5 = 0 samples on the leading edge (the first edge away from idle), and bit 5 = 1 samples on the trailing edge. `sdo_o` is valid at every sampling edge.
- R5: Control bits 7:6 set the master clock half-period in system clocks: code 0 gives 2 (divide by 4), code 1 gives 8 (divide by 16), and codes 2 and 3 give 32 (divide by 64).
- R6: Status bit 0 (done) rises one system clock after the eighth sampling edge, and `irq` follows it. Done stays set until a status write with bit 0 = 0; a write with bit 0 = 1 leaves it unchanged.
- R7: A data write during an active transfer changes neither the register nor the transfer, and it sets status bit 1. Status bit 1 stays set until a status write with bit 1 = 0.
- R8: In master mode with control bit 3 = 1, `ss_n_oe` is 1 and `ss_n_o` is low during a transfer and high otherwise. With control bit 3 = 0, `ss_n_oe` is 0.
- R9: In slave mode (bit 0 set, bit 1 clear), each sampling edge on `sck_i` shifts `sdi_i` in and presents the next bit on `sdo_o`. The received byte is readable once done is set, and `sdo_oe` is 1 only while the port is selected.
- R10: In slave mode with control bit 3 = 1, the port ignores clock edges while `ss_n_i` is high and keeps `sdo_oe` at 0. Raising `ss_n_i` mid-byte discards the partial bit count without setting done.
- R11: In slave mode with control bit 3 = 0, the port ignores `ss_n_i` and transfers normally with it held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | DW | Host write data |
| rd_addr | input | 2 | Host read address |
| rd_data | output | DW | Registered read data |
| irq | output | 1 | Transfer-complete interrupt (mirrors done) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock from an external master |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| ss_n_oe | output | 1 | Select output enable |
| ss_n_i | input | 1 | Active-low select from an external master |

## Verification
Master transfers are swept over all eight combinations of bit order, clock idle level and sampling edge. Each combination uses its own pair of transmit and receive bytes, so a swapped order or a wrong edge yields a different byte in each direction. The bench times the gap between clock toggles under every divider code, which separates the three rates and shows that codes 2 and 3 alias. Slave transfers repeat the same eight-way sweep with an external clock, then cover the select cases: an aborted three-bit fragment before a full byte, which exposes a bit counter that is not reset, and a byte clocked with select high, both with the select pin enabled and with it disabled. A collision write in the middle of a slow transfer shows that the outgoing and incoming bytes are unaffected and that the two flags clear independently.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  // packed from bit 7 down to bit 0
  typedef struct packed {
    logic [1:0] div;      // 7:6 divider code
    logic       late;     // 5   sample on trailing edge
    logic       idle_hi;  // 4   clock idle level
    logic       sel_en;   // 3   select pin in use
    logic       msb;      // 2   most significant bit first
    logic       master;   // 1   master mode
    logic       en;       // 0   port enable
  } ctrl_t;

endpackage

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CW = $clog2(DIV_C / 2) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half_m1;

  always_comb begin
    case (sel)
      2'd0:    half_m1 = CW'(DIV_A / 2 - 1);
      2'd1:    half_m1 = CW'(DIV_B / 2 - 1);
      default: half_m1 = CW'(DIV_C / 2 - 1);
    endcase
  end

  assign tick = run && (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == half_m1) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic ssn_i,
  output logic sck_q,
  output logic sck_prev,
  output logic sdi_q,
  output logic ssn_q
);
  logic [SYNC:0]   sck_p;
  logic [SYNC-1:0] sdi_p;
  logic [SYNC-1:0] ssn_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      sdi_p <= '0;
      ssn_p <= '1;
    end else begin
      sck_p <= {sck_p[SYNC-1:0], sck_i};
      sdi_p <= {sdi_p[SYNC-2:0], sdi_i};
      ssn_p <= {ssn_p[SYNC-2:0], ssn_i};
    end
  end

  assign sck_q    = sck_p[SYNC-1];
  assign sck_prev = sck_p[SYNC];
  assign sdi_q    = sdi_p[SYNC-1];
  assign ssn_q    = ssn_p[SYNC-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          clr,
  input  logic          msb,
  input  logic          in_bit,
  output logic [DW-1:0] sh,
  output logic          sout,
  output logic          mid_byte,
  output logic          done_pend
);
  localparam int CNTW = $clog2(DW);
  localparam logic [CNTW-1:0] LAST = CNTW'(DW - 1);

  logic [CNTW-1:0] cnt;

  assign sout     = msb ? sh[DW-1] : sh[0];
  assign mid_byte = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      cnt       <= '0;
      done_pend <= 1'b0;
    end else begin
      done_pend <= shift && !load && !clr && (cnt == LAST);
      if (load) begin
        sh  <= load_val;
        cnt <= '0;
      end else if (clr) begin
        cnt <= '0;
      end else if (shift) begin
        sh  <= msb ? {sh[DW-2:0], in_bit} : {in_bit, sh[DW-1:1]};
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic          sdi_i,
  output logic          ss_n_o,
  output logic          ss_n_oe,
  input  logic          ss_n_i
);
  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] EDGE_LAST = EW'(2 * DW - 1);

  ctrl_t         ctrl;
  logic          done_f, coll_f, busy_m, sck_r;
  logic [EW-1:0] edge_idx;
  logic          tick;
  logic          sck_q, sck_prev, sdi_q, ssn_q;
  logic [DW-1:0] sh;
  logic          sout, mid_byte, done_pend;

  logic en_on, sel_on, master_on, slave_on, selected, xfer_busy;
  logic data_wr, stat_wr, ctrl_wr, collide, load, start;
  logic m_samp, s_edge, s_lead, s_samp, samp, in_bit, clr;

  assign en_on     = ctrl.en;
  assign sel_on    = ctrl.sel_en;
  assign master_on = ctrl.en & ctrl.master;
  assign slave_on  = ctrl.en & ~ctrl.master;
  assign selected  = ~ctrl.sel_en | ~ssn_q;
  assign xfer_busy = master_on ? busy_m : (slave_on & mid_byte);

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);
  assign stat_wr = wr_en && (wr_addr == REG_STAT);
  assign data_wr = wr_en && (wr_addr == REG_DATA);
  assign collide = data_wr && xfer_busy;
  assign load    = data_wr && !xfer_busy;
  assign start   = load && master_on;

  assign m_samp = busy_m && tick && (edge_idx[0] == ctrl.late);
  assign s_edge = slave_on && selected && (sck_q != sck_prev);
  assign s_lead = (sck_prev == ctrl.idle_hi);
  assign s_samp = s_edge && (s_lead != ctrl.late);
  assign samp   = m_samp | s_samp;
  assign in_bit = master_on ? sdi_i : sdi_q;
  assign clr    = ~ctrl.en | (slave_on & ~selected);

  spi_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
    .clk(clk), .rst(rst), .run(busy_m), .sel(ctrl.div), .tick(tick)
  );

  spi_in_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .sck_i(sck_i), .sdi_i(sdi_i), .ssn_i(ss_n_i),
    .sck_q(sck_q), .sck_prev(sck_prev), .sdi_q(sdi_q), .ssn_q(ssn_q)
  );

  spi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .shift(samp),
    .clr(clr), .msb(ctrl.msb), .in_bit(in_bit), .sh(sh), .sout(sout),
    .mid_byte(mid_byte), .done_pend(done_pend)
  );

  // control register
  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (ctrl_wr) ctrl <= ctrl_t'(wr_data[7:0]);
  end

  // master sequencing: serial clock and edge counter
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m   <= 1'b0;
      edge_idx <= '0;
      sck_r    <= 1'b0;
    end else if (!master_on) begin
      busy_m   <= 1'b0;
      edge_idx <= '0;
      sck_r    <= ctrl.idle_hi;
    end else if (start) begin
      busy_m   <= 1'b1;
      edge_idx <= '0;
      sck_r    <= ctrl.idle_hi;
    end else if (busy_m && tick) begin
      sck_r    <= ~sck_r;
      edge_idx <= edge_idx + 1'b1;
      if (edge_idx == EDGE_LAST) busy_m <= 1'b0;
    end else if (!busy_m) begin
      sck_r <= ctrl.idle_hi;
    end
  end

  // sticky flags: set wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      done_f <= 1'b0;
      coll_f <= 1'b0;
    end else begin
      if (done_pend) done_f <= 1'b1;
      else if (stat_wr && !wr_data[0]) done_f <= 1'b0;
      if (collide) coll_f <= 1'b1;
      else if (stat_wr && !wr_data[1]) coll_f <= 1'b0;
    end
  end

  // registered host read
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        REG_CTRL: rd_data <= DW'(ctrl);
        REG_STAT: rd_data <= {{(DW-2){1'b0}}, coll_f, done_f};
        REG_DATA: rd_data <= sh;
        default:  rd_data <= '0;
      endcase
    end
  end

  assign irq     = done_f;
  assign sck_o   = sck_r;
  assign sck_oe  = master_on;
  assign sdo_o   = sout;
  assign sdo_oe  = master_on | (slave_on & selected);
  assign ss_n_o  = ~busy_m;
  assign ss_n_oe = master_on & ctrl.sel_en;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst,
  input logic en_on,
  input logic sel_on,
  input logic slave_on,
  input logic ssn_q,
  input logic sck_oe,
  input logic sdo_oe,
  input logic ss_n_oe,
  input logic done_f,
  input logic coll_f,
  input logic stat_wr,
  input logic wr_b0,
  input logic wr_b1,
  input logic collide,
  input logic samp
);
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en_on |-> (!sck_oe && !sdo_oe && !ss_n_oe));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (done_f && !(stat_wr && !wr_b0)) |=> done_f);

  p_done_after_sample_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_f) |-> $past(samp, 2));

  p_coll_set_r7: assert property (@(posedge clk) disable iff (rst)
    collide |=> coll_f);

  p_coll_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (coll_f && !(stat_wr && !wr_b1)) |=> coll_f);

  p_ss_float_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_on |-> !ss_n_oe);

  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (slave_on && sel_on && ssn_q) |-> !sdo_oe);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst(rst), .en_on(en_on), .sel_on(sel_on), .slave_on(slave_on),
  .ssn_q(ssn_q), .sck_oe(sck_oe), .sdo_oe(sdo_oe), .ss_n_oe(ss_n_oe),
  .done_f(done_f), .coll_f(coll_f), .stat_wr(stat_wr), .wr_b0(wr_data[0]),
  .wr_b1(wr_data[1]), .collide(collide), .samp(samp)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int H = 6;  // slave-side half period in system clocks

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst, wr_en, irq, sck_o, sck_oe, sck_i, sdo_o, sdo_oe, sdi_i;
  logic       ss_n_o, ss_n_oe, ss_n_i;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  spi_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_i(sck_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .sdi_i(sdi_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe), .ss_n_i(ss_n_i)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic hr(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic logic [7:0] mk(input logic en, master, msb, sel, cpol, late,
                                    input logic [1:0] div);
    return {div, late, cpol, sel, msb, master, en};
  endfunction

  function automatic logic bitof(input logic [7:0] b, input int i, input logic msb);
    return msb ? b[7-i] : b[i];
  endfunction

  // Bench acts as the remote slave while the port is master.
  task automatic master_xfer(input logic msb, cpol, late, sel, input logic [1:0] div,
                             input logic [7:0] tx, mrx, input bit do_coll);
    logic [7:0] got, v;
    logic psck, psdo;
    int edges, nb, guard;
    bit pend;
    got = 0; edges = 0; nb = 0; guard = 0; pend = 0;
    hw(0, mk(1, 1, msb, sel, cpol, late, div));
    hw(1, 8'h00);
    chk("R4 master idle level", sck_o, cpol);
    chk("R8 select enable", ss_n_oe, sel);
    sdi_i = bitof(mrx, 0, msb);
    hw(2, tx);
    psck = sck_o; psdo = sdo_o;
    while (edges < 16 && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (pend) begin chk("R6 done one clock after last sample", irq, 1); pend = 0; end
      if (sck_o != psck) begin
        if (edges == 0 && sel) chk("R8 select low in transfer", ss_n_o, 0);
        if ((edges % 2) == int'(late)) begin
          if (msb) got[7-nb] = psdo; else got[nb] = psdo;
          nb++;
          if (nb == 8) begin chk("R6 done low at last sample", irq, 0); pend = 1; end
          else sdi_i = bitof(mrx, nb, msb);
        end
        edges++;
        if (do_coll && edges == 4) begin
          hw(2, 8'h00);
        end
      end
      psck = sck_o; psdo = sdo_o;
    end
    if (pend) begin @(negedge clk); chk("R6 done one clock after last sample", irq, 1); end
    repeat (3) @(negedge clk);
    chk("R2 R3 R4 transmitted byte", got, tx);
    hr(2, v);
    chk("R2 R3 R4 received byte", v, mrx);
    hr(1, v);
    chk("R6 R7 status after transfer", v, do_coll ? 3 : 1);
    chk("R4 clock back at idle", sck_o, cpol);
    if (sel) chk("R8 select high when idle", ss_n_o, 1);
  endtask

  // Bench acts as the remote master while the port is slave.
  task automatic slave_xfer(input logic msb, cpol, late, sel, input bit use_ss,
                            input int nbits, input logic [7:0] tx, mtx, input string tag);
    logic [7:0] got, v;
    bit live;
    got = 0;
    live = !sel || use_ss;
    hw(0, mk(1, 0, msb, sel, cpol, late, 2'd0));
    hw(2, tx);
    hw(1, 8'h00);
    sck_i = cpol;
    if (use_ss) ss_n_i = 0;
    repeat (H) @(negedge clk);
    chk({tag, " sdo enable"}, sdo_oe, live);
    for (int i = 0; i < nbits; i++) begin
      if (!late) sdi_i = bitof(mtx, i, msb);
      repeat (H) @(negedge clk);
      if (!late) begin if (msb) got[7-i] = sdo_o; else got[i] = sdo_o; end
      sck_i = ~sck_i;
      if (late) sdi_i = bitof(mtx, i, msb);
      repeat (H) @(negedge clk);
      if (late) begin if (msb) got[7-i] = sdo_o; else got[i] = sdo_o; end
      sck_i = ~sck_i;
    end
    repeat (H) @(negedge clk);
    if (use_ss) ss_n_i = 1;
    repeat (4) @(negedge clk);
    chk({tag, " done"}, irq, (live && nbits == 8) ? 1 : 0);
    if (live && nbits == 8) begin
      chk({tag, " transmitted byte"}, got, tx);
      hr(2, v);
      chk({tag, " received byte"}, v, mtx);
    end
    chk({tag, " select pin floated"}, ss_n_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    logic [7:0] v;
    int t, tog, cfg;
    logic p;
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    sck_i = 0; sdi_i = 0; ss_n_i = 1;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    chk("R1 reset irq", irq, 0);
    chk("R1 reset sck_oe", sck_oe, 0);
    chk("R1 reset sdo_oe", sdo_oe, 0);
    chk("R1 reset ss_n_oe", ss_n_oe, 0);
    hr(0, v); chk("R1 reset control", v, 0);
    hr(1, v); chk("R6 reset status", v, 0);

    // R1: disabled port does nothing on a data write
    hw(0, mk(0, 1, 1, 1, 0, 0, 2'd0));
    hw(2, 8'h5A);
    tog = 0; p = sck_o;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sck_o != p) tog++;
      p = sck_o;
    end
    chk("R1 no clock toggles", tog, 0);
    chk("R1 no done", irq, 0);
    chk("R1 sck_oe off", sck_oe, 0);
    chk("R1 sdo_oe off", sdo_oe, 0);
    chk("R1 ss_n_oe off", ss_n_oe, 0);
    hr(2, v); chk("R1 data loaded only", v, 8'h5A);

    // R2 R3 R4 R6 R8: master sweep
    cfg = 0;
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 2; l++) begin
          master_xfer(m[0], c[0], l[0], m[0] ^ c[0], 2'd0,
                      8'h3C ^ 8'(cfg * 37), 8'hA9 + 8'(cfg * 19), 0);
          cfg++;
        end

    // R5: divider half periods
    for (int d = 0; d < 4; d++) begin
      hw(0, mk(1, 1, 1, 0, 0, 0, 2'(d)));
      hw(1, 8'h00);
      hw(2, 8'h11);
      p = sck_o;
      t = 0;
      while (sck_o == p && t < 200) begin @(negedge clk); t++; end
      p = sck_o; t = 0;
      while (sck_o == p && t < 200) begin @(negedge clk); t++; end
      chk("R5 half period", t, (d == 0) ? 2 : (d == 1) ? 8 : 32);
      t = 0;
      while (!irq && t < 2000) begin @(negedge clk); t++; end
      repeat (80) @(negedge clk);
    end

    // R7: collision in a slow transfer, then independent clears (R6)
    master_xfer(1, 0, 0, 1, 2'd2, 8'hC3, 8'h96, 1);
    hw(1, 8'h01);
    hr(1, v); chk("R7 collision clears, done stays", v, 1);
    hw(1, 8'h02);
    hr(1, v); chk("R6 done clears by writing 0", v, 0);
    chk("R6 irq follows done", irq, 0);

    // R9: slave sweep
    cfg = 0;
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 2; l++) begin
          slave_xfer(m[0], c[0], l[0], 1, 1, 8, 8'h5E + 8'(cfg * 29),
                     8'h81 ^ 8'(cfg * 53), "R9 slave");
          cfg++;
        end

    // R10: partial byte then deselect, followed by a full byte
    slave_xfer(1, 0, 0, 1, 1, 3, 8'hF0, 8'hFF, "R10 aborted fragment");
    hr(1, v); chk("R10 no done after abort", v, 0);
    slave_xfer(1, 0, 0, 1, 1, 8, 8'h24, 8'hB7, "R10 after abort");

    // R10: select held high, edges ignored
    ss_n_i = 1;
    slave_xfer(0, 1, 1, 1, 0, 8, 8'h0F, 8'h6D, "R10 deselected");

    // R11: select pin not in use, select input high
    ss_n_i = 1;
    slave_xfer(0, 1, 0, 0, 0, 8, 8'h9A, 8'h47, "R11 select ignored");

    summary();
  end
endmodule